// File: doc/BRIEF.md
# Serial-to-Superword Write Buffer with Dual-Slot Drain

This block sits between a byte-wide sample stream and a wide video store. Bytes arrive one per sample clock, qualified by a valid strobe. They are packed in sequence into 16-byte superwords. Each finished superword joins a small first-in first-out store that holds up to four of them until the store's write slots take them.

The downstream memory runs a repeating cycle that offers two write opportunities, called slot A and slot B. Normally only slot A takes a word, so one superword leaves per memory cycle. When input runs well ahead of output, as in fast forward shuttle, the dual-load enable lets slot B take the next pending word too. Two words then leave in one memory cycle and the backlog drains.

A fifth completed word that finds no room is discarded, and a sticky overflow flag is raised. The occupancy count is always visible.

Top module: `sw_pack_buffer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the store, clears the overflow flag and returns byte assembly to the first byte position. In the first cycle after reset, `pendCount` is 0 and `overflow` is 0.
- R2: Within a superword, the k-th accepted byte (k = 0..15) occupies bits [8k+7:8k] of `wordOut`. The first byte is in the least significant position.
- R3: A byte presented while `byteValid` is low is ignored. It neither enters a superword nor advances the byte position.
- R4: Superwords leave in the order they were completed. Each is written exactly once, and `wordOut` carries the oldest pending word whenever a write strobe is high.
- R5: When `slotA` is high and at least one word is pending, `wordWrA` is high in that same cycle and the oldest word is removed. With nothing pending, neither strobe rises.
- R6: When `dualLoad` is high, `slotB` is high, `slotA` is low and a word is pending, `wordWrB` is high in that same cycle and the oldest word is removed. Slot A and slot B in successive cycles thus drain two words in one memory cycle.
- R7: While `dualLoad` is low, `wordWrB` stays low and a `slotB` pulse removes nothing.
- R8: `pendCount` gives the number of pending words, from 0 to 4, updated one cycle after the change. When the 16th byte arrives with four words pending and a write strobe fires in the same cycle, the new word is accepted.
- R9: When the 16th byte arrives with four words pending and no write in that cycle, the new word is dropped and the stored words are kept. `overflow` rises on the next cycle and stays high until reset.
- R10: If `slotA` and `slotB` are high in the same cycle, only slot A is served.
- R11: A reset that arrives part-way through a superword discards the partial bytes. The next 16 valid bytes form a complete word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | Qualifies `byteIn` this cycle |
| byteIn | input | 8 | Incoming sample byte |
| slotA | input | 1 | Memory write slot A opportunity |
| slotB | input | 1 | Memory write slot B opportunity |
| dualLoad | input | 1 | Allows slot B to take a word |
| wordOut | output | 128 | Oldest pending superword |
| wordWrA | output | 1 | Word written in slot A this cycle |
| wordWrB | output | 1 | Word written in slot B this cycle |
| pendCount | output | 3 | Number of pending superwords |
| overflow | output | 1 | Sticky flag: a completed word was dropped |

## Verification
The write strobes and the word on `wordOut` answer in the same cycle as the slot request. A word completed at a clock edge becomes the head, and is counted in `pendCount`, from the next cycle. The overflow flag likewise rises one cycle after the dropping edge. The bench drives each input on the falling edge, samples 1 ns later, and compares against a reference queue. That queue is advanced only after the comparison, so the count and flag it expects are the values registered at the previous rising edge.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 16;
  localparam int DEPTH      = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int IDX_W      = $clog2(WORD_BYTES);
  localparam int PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  // strobes from the control to the datapath
  typedef struct packed {
    logic             capture;   // store a non-final byte
    logic [IDX_W-1:0] byteSel;   // byte position being filled
    logic             push;      // final byte: write whole word into store
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
  } swb_strobe_t;
endpackage

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byteValid,
  input  logic             slotA,
  input  logic             slotB,
  input  logic             dualLoad,
  output swb_strobe_t      ctl,
  output logic             wrA,
  output logic             wrB,
  output logic [CNT_W-1:0] pendCount,
  output logic             overflow
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] byteIdx;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             ovfReg;
  logic             lastByte, haveWord, serveA, serveB, pop, room, push, drop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    lastByte = byteValid && (byteIdx == LAST_IDX);
    haveWord = (count != '0);
    serveA   = slotA && haveWord;
    serveB   = slotB && !slotA && dualLoad && haveWord;
    pop      = serveA || serveB;
    room     = (count < FULL_CNT) || pop;
    push     = lastByte && room;
    drop     = lastByte && !room;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteIdx <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      ovfReg  <= 1'b0;
    end else begin
      if (byteValid) byteIdx <= lastByte ? '0 : byteIdx + IDX_W'(1);
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (drop) ovfReg <= 1'b1;
    end
  end

  always_comb begin
    ctl.capture = byteValid && !lastByte;
    ctl.byteSel = byteIdx;
    ctl.push    = push;
    ctl.wrPtr   = wrPtr;
    ctl.rdPtr   = rdPtr;
  end

  assign wrA       = serveA;
  assign wrB       = serveB;
  assign pendCount = count;
  assign overflow  = ovfReg;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pendCount == '0 && !overflow));
  // R8
  cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pendCount <= FULL_CNT);
  // R7
  slotb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wrB |-> dualLoad);
  // R5
  empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pendCount == '0) |-> (!wrA && !wrB));
  // R10
  one_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (slotA && slotB) |-> !wrB);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> ($past(pendCount) == FULL_CNT));
endmodule

// File: rtl/swb_datapath.sv
module swb_datapath
  import swb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byteIn,
  input  swb_strobe_t       ctl,
  output logic [WORD_W-1:0] wordOut
);
  localparam int PART_N = WORD_BYTES - 1;

  logic [BYTE_W-1:0] partBytes [PART_N];
  logic [WORD_W-1:0] wordMem   [DEPTH];
  logic [WORD_W-1:0] assembled;

  // earlier bytes from the staging registers, final byte straight from input
  for (genvar k = 0; k < PART_N; k++) begin : g_pack
    assign assembled[k*BYTE_W +: BYTE_W] = partBytes[k];
  end
  assign assembled[PART_N*BYTE_W +: BYTE_W] = byteIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PART_N; k++) partBytes[k] <= '0;
      for (int d = 0; d < DEPTH; d++)  wordMem[d]   <= '0;
    end else begin
      if (ctl.capture) partBytes[ctl.byteSel] <= byteIn;
      if (ctl.push)    wordMem[ctl.wrPtr]     <= assembled;
    end
  end

  assign wordOut = wordMem[ctl.rdPtr];

  // R2
  push_lastbyte_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.push |-> (ctl.byteSel == IDX_W'(WORD_BYTES - 1) && !ctl.capture));
endmodule

// File: rtl/sw_pack_buffer.sv
module sw_pack_buffer
  import swb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              slotA,
  input  logic              slotB,
  input  logic              dualLoad,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordWrA,
  output logic              wordWrB,
  output logic [CNT_W-1:0]  pendCount,
  output logic              overflow
);
  swb_strobe_t ctl;

  swb_ctrl u_ctrl (
    .clk(clk), .rst(rst), .byteValid(byteValid), .slotA(slotA), .slotB(slotB),
    .dualLoad(dualLoad), .ctl(ctl), .wrA(wordWrA), .wrB(wordWrB),
    .pendCount(pendCount), .overflow(overflow)
  );

  swb_datapath u_dp (
    .clk(clk), .rst(rst), .byteIn(byteIn), .ctl(ctl), .wordOut(wordOut)
  );
endmodule

// File: tb/sw_pack_buffer_bench.sv
`timescale 1ns/1ps
module sw_pack_buffer_bench;
  import swb_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst = 1'b1, byteValid = 1'b0, slotA = 1'b0, slotB = 1'b0, dualLoad = 1'b0;
  logic [BYTE_W-1:0] byteIn = '0;
  logic [WORD_W-1:0] wordOut;
  logic              wordWrA, wordWrB, overflow;
  logic [CNT_W-1:0]  pendCount;

  sw_pack_buffer u_sw_pack_buffer (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteIn(byteIn), .slotA(slotA),
    .slotB(slotB), .dualLoad(dualLoad), .wordOut(wordOut), .wordWrA(wordWrA),
    .wordWrB(wordWrB), .pendCount(pendCount), .overflow(overflow)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [WORD_W-1:0] expQ [$];
  logic [BYTE_W-1:0] mPart [WORD_BYTES];
  int  mIdx = 0;
  bit  mOvf = 0;

  function automatic logic [BYTE_W-1:0] byteOf(input int s, input int k);
    return BYTE_W'(s * 29 + k * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver + monitor for one cycle: drive at falling edge, compare 1 ns later
  task automatic step(input bit bv, input logic [BYTE_W-1:0] b, input bit sA, input bit sB);
    bit expA, expB;
    logic [WORD_W-1:0] w;
    @(negedge clk);
    byteValid = bv; byteIn = b; slotA = sA; slotB = sB;
    #1;
    check(pendCount == CNT_W'(expQ.size()), "R8", "pending count", pendCount, expQ.size());
    check(overflow == mOvf, "R9", "overflow flag", overflow, mOvf);
    expA = sA && (expQ.size() > 0);
    expB = sB && !sA && dualLoad && (expQ.size() > 0);
    check(wordWrA == expA, "R5", "slot A strobe", wordWrA, expA);
    check(wordWrB == expB, !dualLoad ? "R7" : (sA ? "R10" : "R6"), "slot B strobe", wordWrB, expB);
    if (expA || expB) begin
      check(wordOut == expQ[0], "R4", "word leaving store", wordOut, expQ[0]);
      void'(expQ.pop_front());
    end
    if (bv) begin
      if (mIdx == WORD_BYTES - 1) begin
        for (int k = 0; k < WORD_BYTES - 1; k++) w[k*BYTE_W +: BYTE_W] = mPart[k];
        w[(WORD_BYTES-1)*BYTE_W +: BYTE_W] = b;
        if (expQ.size() < DEPTH) expQ.push_back(w);
        else mOvf = 1;
        mIdx = 0;
      end else begin
        mPart[mIdx] = b;
        mIdx++;
      end
    end
  endtask

  task automatic sendWord(input int s, input bit gaps);
    for (int k = 0; k < WORD_BYTES; k++) begin
      if (gaps) step(1'b0, 8'hEE, 1'b0, 1'b0);
      step(1'b1, byteOf(s, k), 1'b0, 1'b0);
    end
  endtask

  task automatic peek(input string req);
    @(negedge clk);
    byteValid = 0; slotA = 0; slotB = 0;
    #1;
    check(wordOut == expQ[0], req, "head word", wordOut, expQ[0]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; byteValid = 0; slotA = 0; slotB = 0;
    @(negedge clk);
    rst = 0;
    expQ.delete(); mIdx = 0; mOvf = 0;
    #1;
    check(pendCount == '0 && !overflow, "R1", "state after reset", {pendCount, overflow}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    doReset();
    step(0, 8'h00, 1, 0);                       // R5: empty store, no strobe

    // R2 R3: gapped word, garbage on invalid cycles
    sendWord(1, 1);
    peek("R3");
    check(wordOut[7:0] == byteOf(1, 0), "R2", "first byte position", wordOut[7:0], byteOf(1, 0));
    check(wordOut[WORD_W-1 -: 8] == byteOf(1, 15), "R2", "last byte position",
          wordOut[WORD_W-1 -: 8], byteOf(1, 15));
    step(0, 8'h00, 1, 0);

    // R7: slot B ignored without dual-load
    sendWord(2, 0); sendWord(3, 0);
    step(0, 8'h00, 0, 1); step(0, 8'h00, 0, 1);
    step(0, 8'h00, 1, 0); step(0, 8'h00, 1, 0);

    // R6 R10: dual-load drain
    dualLoad = 1;
    sendWord(4, 0); sendWord(5, 0); sendWord(6, 0);
    step(0, 8'h00, 1, 0); step(0, 8'h00, 0, 1);
    step(0, 8'h00, 1, 1); step(0, 8'h00, 0, 1);

    // R9: fifth word dropped; R8: full with simultaneous write accepted
    dualLoad = 0;
    for (int s = 7; s < 12; s++) sendWord(s, 0);
    for (int k = 0; k < WORD_BYTES - 1; k++) step(1, byteOf(12, k), 0, 0);
    step(1, byteOf(12, WORD_BYTES - 1), 1, 0);
    step(0, 8'h00, 0, 0);
    for (int n = 0; n < 5; n++) step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);

    // R11: reset mid-word
    for (int k = 0; k < 7; k++) step(1, byteOf(13, k), 0, 0);
    doReset();
    sendWord(14, 0);
    peek("R11");
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule